// File: doc/BRIEF.md
# Zoomable Sprite Overlay with Collision Tracking

This block puts six independent sprites on top of a background pixel stream that is generated elsewhere. Each sprite is a 32x32 image with 8 bits per pixel, held in its own on-chip store. The block places it at a programmable screen position. Each axis can be magnified by 1, 2, 4 or 8. A sprite pixel leaves the block with a 2-bit palette bank in front of it, so sprites keep their full 256-colour depth whatever colour depth the background uses.

A simple register port sets each sprite's control word. Position and magnification written through this port take effect only on the next frame-start pulse, so a sprite never tears in mid-frame. The palette bank takes effect at once.

For every pair of sprites, a sticky collision register records whether the two ever showed opaque pixels at the same screen position. Software reads this register, and the read also clears it. The pixel path is a fixed two-stage pipeline: a read of the sprite store, then a priority merge.

Top module: `sprite_overlay`

## Requirements
- R1: The image of sprite s is loaded through the memory write port with `mem_spr_i` = s. Pixel (column c, row r) sits at address r*32 + c, and the value written there is the value the sprite shows at that pixel.
- R2: Register slots 9 to 14 hold the control words of sprites 0 to 5. Field layout: [13:0] X position, [15:14] X zoom, [27:16] Y position, [29:28] palette bank, [31:30] Y zoom. A read of one of these slots returns the last word written to it, on `reg_rdata_o` in the cycle after the read strobe.
- R3: With zoom code z, a sprite spans 32*2^z screen pixels on that axis, starting at its position. A screen offset d from the position maps to sprite column (or row) d >> z. Pixels left of, above, right of or below the span are not covered.
- R4: A sprite pixel of value 0 is transparent. Where no opaque sprite pixel covers a position, `pix_o` = {2'b00, background index} and `pix_sel_o` = 0.
- R5: Where opaque sprite pixels cover a position, the lowest-numbered of those sprites wins. `pix_o` = {its palette bank, its pixel value} and `pix_sel_o` = 1.
- R6: A pixel presented in cycle t produces its result on `pix_o` / `pix_sel_o` in cycle t+2.
- R7: Written position and zoom values take effect only after a cycle with `frame_start_i` high. A written palette bank takes effect immediately.
- R8: Slot 15 is the collision register. Bit a*(11-a)/2 + (b-a-1) belongs to the sprite pair a<b (pair 0-1 is bit 0, pair 4-5 is bit 14). The bit sets when both sprites show opaque pixels at one valid position, and it stays set until read.
- R9: A read of slot 15 returns the collision bits in [14:0], with zeros above, and clears the register. Hits arriving in the cycle of the clear are kept.
- R10: Writes to slots 0 to 8 and slot 15 have no effect. Reads of slots 0 to 8 return zero.
- R11: While `pix_valid_i` is low, no sprite is shown and no collision is recorded. The output carries the background index.
- R12: After reset, all control words, the collision register, `reg_rdata_o`, `pix_o` and `pix_sel_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 4 | Register slot |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, one cycle after the strobe |
| mem_we_i | input | 1 | Sprite image write strobe |
| mem_spr_i | input | 3 | Sprite selected for the image write |
| mem_addr_i | input | 10 | Image address, row*32 + column |
| mem_wdata_i | input | 8 | Image pixel value |
| frame_start_i | input | 1 | Frame start pulse; applies the pending geometry |
| pix_valid_i | input | 1 | Current screen position is in the active area |
| pix_x_i | input | 14 | Screen X of the current pixel |
| pix_y_i | input | 12 | Screen Y of the current pixel |
| bg_pix_i | input | 8 | Background colour index of the current pixel |
| pix_o | output | 10 | Final colour: {bank, sprite value} or {00, background} |
| pix_sel_o | output | 1 | High when a sprite pixel was chosen |

## Verification
The assertions check, on every cycle, the invariants of the output and of the collision register. A chosen sprite pixel is never value 0. A background pixel never carries a bank. Collision bits drop only after a read of slot 15. The data returned by that read equals the register as it stood before the clear. Active geometry changes only after a frame-start pulse. Idle cycles never produce a sprite pixel. The correctness of each output colour cannot be shown this way, because it depends on stored images, magnification and the priority order. The bench scenarios cover it with a reference model, and they also cover the exact bit chosen for each overlapping pair and the deferral of geometry against the immediate bank change.

// File: rtl/spr_ovl_pkg.sv
package spr_ovl_pkg;
  localparam int unsigned NSPR      = 6;
  localparam int unsigned SIDE_W    = 5;
  localparam int unsigned PIX_W     = 8;
  localparam int unsigned BANK_W    = 2;
  localparam int unsigned ZOOM_W    = 2;
  localparam int unsigned XPOS_W    = 14;
  localparam int unsigned YPOS_W    = 12;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned SLOT_W    = 4;
  localparam int unsigned SLOT_SPR0 = 9;
  localparam int unsigned SLOT_COLL = 15;

  // control word as seen on the register port
  typedef struct packed {
    logic [ZOOM_W-1:0] zoom_y;
    logic [BANK_W-1:0] bank;
    logic [YPOS_W-1:0] pos_y;
    logic [ZOOM_W-1:0] zoom_x;
    logic [XPOS_W-1:0] pos_x;
  } spr_ctl_t;

  // frame-latched geometry
  typedef struct packed {
    logic [ZOOM_W-1:0] zoom_y;
    logic [YPOS_W-1:0] pos_y;
    logic [ZOOM_W-1:0] zoom_x;
    logic [XPOS_W-1:0] pos_x;
  } spr_geo_t;

  function automatic int unsigned pair_bit(int unsigned a, int unsigned b, int unsigned n);
    return a * (2 * n - a - 1) / 2 + (b - a - 1);
  endfunction
endpackage

// File: rtl/spr_regs.sv
module spr_regs
  import spr_ovl_pkg::*;
#(
  parameter int unsigned NSPR = 6
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [SLOT_W-1:0]     addr_i,
  input  logic [REG_W-1:0]      wdata_i,
  input  logic                  frame_start_i,
  output spr_ctl_t [NSPR-1:0]   shadow_o,
  output spr_geo_t [NSPR-1:0]   geo_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_o <= '0;
      geo_o    <= '0;
    end else begin
      for (int s = 0; s < int'(NSPR); s++) begin
        if (we_i && addr_i == SLOT_W'(int'(SLOT_SPR0) + s)) shadow_o[s] <= spr_ctl_t'(wdata_i);
        if (frame_start_i) begin
          geo_o[s].zoom_y <= shadow_o[s].zoom_y;
          geo_o[s].pos_y  <= shadow_o[s].pos_y;
          geo_o[s].zoom_x <= shadow_o[s].zoom_x;
          geo_o[s].pos_x  <= shadow_o[s].pos_x;
        end
      end
    end
  end
endmodule

// File: rtl/spr_unit.sv
module spr_unit
  import spr_ovl_pkg::*;
#(
  parameter int unsigned SIDE_W = 5,
  localparam int unsigned AW    = 2 * SIDE_W,
  localparam int unsigned DEPTH = 1 << AW,
  localparam int unsigned COL_W = BANK_W + PIX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  spr_geo_t          geo_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              valid_i,
  input  logic [XPOS_W-1:0] pix_x_i,
  input  logic [YPOS_W-1:0] pix_y_i,
  input  logic              mem_we_i,
  input  logic [AW-1:0]     mem_addr_i,
  input  logic [PIX_W-1:0]  mem_wdata_i,
  output logic              opaque_o,
  output logic [COL_W-1:0]  color_o
);
  logic [XPOS_W-1:0] dx, col;
  logic [YPOS_W-1:0] dy, row;
  logic              in_x, in_y;

  always_comb begin
    dx   = pix_x_i - geo_i.pos_x;
    dy   = pix_y_i - geo_i.pos_y;
    col  = dx >> geo_i.zoom_x;
    row  = dy >> geo_i.zoom_y;
    // inside when offset is non-negative and the unzoomed index fits the side
    in_x = (pix_x_i >= geo_i.pos_x) && (col[XPOS_W-1:SIDE_W] == '0);
    in_y = (pix_y_i >= geo_i.pos_y) && (row[YPOS_W-1:SIDE_W] == '0);
  end

  logic [PIX_W-1:0]  img_q [DEPTH];
  logic [PIX_W-1:0]  rd_q;
  logic              hit_q;
  logic [BANK_W-1:0] bank_q;

  always_ff @(posedge clk_i) begin
    if (mem_we_i) img_q[mem_addr_i] <= mem_wdata_i;
    rd_q <= img_q[{row[SIDE_W-1:0], col[SIDE_W-1:0]}];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q  <= 1'b0;
      bank_q <= '0;
    end else begin
      hit_q  <= valid_i & in_x & in_y;
      bank_q <= bank_i;
    end
  end

  assign opaque_o = hit_q && (rd_q != '0);
  assign color_o  = {bank_q, rd_q};
endmodule

// File: rtl/spr_mix.sv
module spr_mix
  import spr_ovl_pkg::*;
#(
  parameter int unsigned NSPR  = 6,
  localparam int unsigned NPAIR = NSPR * (NSPR - 1) / 2,
  localparam int unsigned COL_W = BANK_W + PIX_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NSPR-1:0]            opaque_i,
  input  logic [NSPR-1:0][COL_W-1:0] color_i,
  input  logic [PIX_W-1:0]           bg_i,
  input  logic                       coll_clr_i,
  output logic [COL_W-1:0]           pix_o,
  output logic                       pix_sel_o,
  output logic [NPAIR-1:0]           coll_o,
  output logic [NPAIR-1:0]           pair_hit_o
);
  logic [COL_W-1:0] win;

  // scan from the highest index down so sprite 0 ends up on top
  always_comb begin
    win = {{BANK_W{1'b0}}, bg_i};
    for (int s = int'(NSPR) - 1; s >= 0; s--) begin
      if (opaque_i[s]) win = color_i[s];
    end
  end

  for (genvar a = 0; a < NSPR; a++) begin : g_a
    for (genvar b = a + 1; b < NSPR; b++) begin : g_b
      assign pair_hit_o[pair_bit(a, b, NSPR)] = opaque_i[a] & opaque_i[b];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_o     <= '0;
      pix_sel_o <= 1'b0;
      coll_o    <= '0;
    end else begin
      pix_o     <= win;
      pix_sel_o <= |opaque_i;
      coll_o    <= (coll_clr_i ? '0 : coll_o) | pair_hit_o;
    end
  end
endmodule

// File: rtl/sprite_overlay.sv
module sprite_overlay
  import spr_ovl_pkg::*;
#(
  parameter int unsigned NSPR   = spr_ovl_pkg::NSPR,
  parameter int unsigned SIDE_W = spr_ovl_pkg::SIDE_W,
  localparam int unsigned SEL_W = $clog2(NSPR),
  localparam int unsigned AW    = 2 * SIDE_W,
  localparam int unsigned NPAIR = NSPR * (NSPR - 1) / 2,
  localparam int unsigned COL_W = BANK_W + PIX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [SLOT_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              mem_we_i,
  input  logic [SEL_W-1:0]  mem_spr_i,
  input  logic [AW-1:0]     mem_addr_i,
  input  logic [PIX_W-1:0]  mem_wdata_i,
  input  logic              frame_start_i,
  input  logic              pix_valid_i,
  input  logic [XPOS_W-1:0] pix_x_i,
  input  logic [YPOS_W-1:0] pix_y_i,
  input  logic [PIX_W-1:0]  bg_pix_i,
  output logic [COL_W-1:0]  pix_o,
  output logic              pix_sel_o
);
  spr_ctl_t [NSPR-1:0]       shadow;
  spr_geo_t [NSPR-1:0]       geo;
  logic [NSPR-1:0]           opaque;
  logic [NSPR-1:0][COL_W-1:0] color;
  logic [NPAIR-1:0]          coll, pair_hit;
  logic [PIX_W-1:0]          bg_d;
  logic                      coll_rd;
  logic [REG_W-1:0]          rd_mux;

  spr_regs #(.NSPR(NSPR)) i_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .we_i          (reg_we_i),
    .addr_i        (reg_addr_i),
    .wdata_i       (reg_wdata_i),
    .frame_start_i (frame_start_i),
    .shadow_o      (shadow),
    .geo_o         (geo)
  );

  for (genvar s = 0; s < NSPR; s++) begin : g_spr
    spr_unit #(.SIDE_W(SIDE_W)) i_unit (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .geo_i       (geo[s]),
      .bank_i      (shadow[s].bank),
      .valid_i     (pix_valid_i),
      .pix_x_i     (pix_x_i),
      .pix_y_i     (pix_y_i),
      .mem_we_i    (mem_we_i && mem_spr_i == SEL_W'(s)),
      .mem_addr_i  (mem_addr_i),
      .mem_wdata_i (mem_wdata_i),
      .opaque_o    (opaque[s]),
      .color_o     (color[s])
    );
  end

  // background waits one cycle to meet the image read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bg_d <= '0;
    else         bg_d <= bg_pix_i;
  end

  spr_mix #(.NSPR(NSPR)) i_mix (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .opaque_i   (opaque),
    .color_i    (color),
    .bg_i       (bg_d),
    .coll_clr_i (coll_rd),
    .pix_o      (pix_o),
    .pix_sel_o  (pix_sel_o),
    .coll_o     (coll),
    .pair_hit_o (pair_hit)
  );

  assign coll_rd = reg_re_i && (reg_addr_i == SLOT_W'(SLOT_COLL));

  always_comb begin
    rd_mux = '0;
    for (int s = 0; s < int'(NSPR); s++) begin
      if (reg_addr_i == SLOT_W'(int'(SLOT_SPR0) + s)) rd_mux = shadow[s];
    end
    if (coll_rd) rd_mux = REG_W'(coll);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       reg_rdata_o <= '0;
    else if (reg_re_i) reg_rdata_o <= rd_mux;
  end
endmodule

// File: rtl/spr_ovl_chk.sv
module spr_ovl_chk
  import spr_ovl_pkg::*;
#(
  parameter int unsigned NSPR  = 6,
  localparam int unsigned NPAIR = NSPR * (NSPR - 1) / 2
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       frame_start_i,
  input logic                       pix_valid_i,
  input logic                       coll_rd_i,
  input logic [NPAIR-1:0]           coll_i,
  input logic [NPAIR-1:0]           pair_hit_i,
  input logic [REG_W-1:0]           rdata_i,
  input logic [BANK_W+PIX_W-1:0]    pix_i,
  input logic                       pix_sel_i,
  input spr_geo_t [NSPR-1:0]        geo_i
);
  AST_NO_CLEAR_SHOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_sel_i |-> pix_i[PIX_W-1:0] != '0); // R4

  AST_BG_NO_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_sel_i |-> pix_i[BANK_W+PIX_W-1:PIX_W] == '0); // R4

  AST_COLL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(coll_rd_i) |-> (coll_i & $past(coll_i)) == $past(coll_i)); // R8

  AST_COLL_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(coll_rd_i) |-> coll_i == $past(pair_hit_i)); // R9

  AST_COLL_READ_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(coll_rd_i) |-> rdata_i == {{(REG_W-NPAIR){1'b0}}, $past(coll_i)}); // R9

  AST_GEO_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(frame_start_i) |-> $stable(geo_i)); // R7

  AST_IDLE_NO_SPRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(pix_valid_i, 2) |-> !pix_sel_i); // R11
endmodule

bind sprite_overlay spr_ovl_chk #(.NSPR(NSPR)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .frame_start_i (frame_start_i),
  .pix_valid_i   (pix_valid_i),
  .coll_rd_i     (coll_rd),
  .coll_i        (coll),
  .pair_hit_i    (pair_hit),
  .rdata_i       (reg_rdata_o),
  .pix_i         (pix_o),
  .pix_sel_i     (pix_sel_o),
  .geo_i         (geo)
);

// File: tb/test_sprite_overlay.sv
module test_sprite_overlay;
  localparam int NS = 6;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 0, reg_re_i = 0;
  logic [3:0]  reg_addr_i = 0;
  logic [31:0] reg_wdata_i = 0;
  logic [31:0] reg_rdata_o;
  logic        mem_we_i = 0;
  logic [2:0]  mem_spr_i = 0;
  logic [9:0]  mem_addr_i = 0;
  logic [7:0]  mem_wdata_i = 0;
  logic        frame_start_i = 0, pix_valid_i = 0;
  logic [13:0] pix_x_i = 0;
  logic [11:0] pix_y_i = 0;
  logic [7:0]  bg_pix_i = 0;
  logic [9:0]  pix_o;
  logic        pix_sel_o;

  always #2 clk_i = ~clk_i; // 4 ns period

  sprite_overlay i_sprite_overlay (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .reg_we_i(reg_we_i), .reg_re_i(reg_re_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .mem_we_i(mem_we_i), .mem_spr_i(mem_spr_i), .mem_addr_i(mem_addr_i), .mem_wdata_i(mem_wdata_i),
    .frame_start_i(frame_start_i), .pix_valid_i(pix_valid_i),
    .pix_x_i(pix_x_i), .pix_y_i(pix_y_i), .bg_pix_i(bg_pix_i),
    .pix_o(pix_o), .pix_sel_o(pix_sel_o)
  );

  int vectors = 0, errors = 0;
  logic [31:0] m_sh [NS];
  logic [31:0] m_act [NS];
  logic [14:0] m_coll;

  logic [9:0] e1_pix, e2_pix;
  bit         e1_sel, e2_sel, e1_v, e2_v;
  string      e1_tag, e2_tag;
  bit         rd_pend;
  logic [31:0] rd_exp;
  string      rd_tag;

  function automatic logic [7:0] spr_px(int s, int a);
    logic [31:0] h;
    h = 32'(a) * 32'd2654435761 ^ (32'(s) * 32'd97531 + 32'd17);
    h = h ^ (h >> 15);
    if (h[21:20] == 2'b00) return 8'h00;
    return h[7:0];
  endfunction

  function automatic void model_pix(input int x, input int y, input bit valid,
                                    input logic [7:0] bg, output logic [9:0] p, output bit sel);
    bit         op [NS];
    logic [9:0] c [NS];
    int         k;
    p = {2'b00, bg};
    sel = 0;
    for (int s = 0; s < NS; s++) begin
      int px, py, zx, zy, w, h;
      logic [7:0] v;
      px = int'(m_act[s][13:0]);  py = int'(m_act[s][27:16]);
      zx = int'(m_act[s][15:14]); zy = int'(m_act[s][31:30]);
      w = 32 << zx; h = 32 << zy;
      op[s] = 0; c[s] = '0;
      if (valid && x >= px && x < px + w && y >= py && y < py + h) begin
        v = spr_px(s, ((y - py) >> zy) * 32 + ((x - px) >> zx));
        op[s] = (v != 0);
        c[s] = {m_sh[s][29:28], v};
      end
    end
    for (int s = NS - 1; s >= 0; s--) if (op[s]) begin p = c[s]; sel = 1; end
    k = 0;
    for (int a = 0; a < NS; a++)
      for (int b = a + 1; b < NS; b++) begin
        if (op[a] && op[b]) m_coll[k] = 1'b1;
        k++;
      end
  endfunction

  // advance to the next falling edge, check what is due, return inputs to idle
  task automatic tick();
    @(negedge clk_i);
    if (e2_v) begin
      vectors++;
      if (pix_o !== e2_pix || pix_sel_o !== e2_sel) begin
        errors++;
        $display("FAIL %s/R6 pixel act=%h/%0d exp=%h/%0d", e2_tag, pix_o, pix_sel_o, e2_pix, e2_sel);
      end
    end
    if (rd_pend) begin
      vectors++;
      if (reg_rdata_o !== rd_exp) begin
        errors++;
        $display("FAIL %s rdata act=%h exp=%h", rd_tag, reg_rdata_o, rd_exp);
      end
      rd_pend = 0;
    end
    e2_v = e1_v; e2_pix = e1_pix; e2_sel = e1_sel; e2_tag = e1_tag;
    e1_v = 1; e1_pix = '0; e1_sel = 0; e1_tag = "R11";
    reg_we_i = 0; reg_re_i = 0; mem_we_i = 0; frame_start_i = 0;
    pix_valid_i = 0; pix_x_i = 0; pix_y_i = 0; bg_pix_i = 0;
  endtask

  task automatic pixel(input int x, input int y, input bit v, input logic [7:0] bg, input string tag);
    logic [9:0] p; bit s;
    tick();
    pix_valid_i = v; pix_x_i = 14'(x); pix_y_i = 12'(y); bg_pix_i = bg;
    model_pix(x, y, v, bg, p, s);
    e1_pix = p; e1_sel = s; e1_tag = v ? tag : "R11";
  endtask

  task automatic wr(input int slot, input logic [31:0] d);
    tick();
    reg_we_i = 1; reg_addr_i = 4'(slot); reg_wdata_i = d;
    if (slot >= 9 && slot <= 14) m_sh[slot-9] = d;
  endtask

  task automatic frame();
    tick();
    frame_start_i = 1;
    for (int s = 0; s < NS; s++) m_act[s] = m_sh[s];
  endtask

  task automatic rd(input int slot, input string tag);
    tick(); tick();
    tick();
    reg_re_i = 1; reg_addr_i = 4'(slot);
    if (slot >= 9 && slot <= 14) rd_exp = m_sh[slot-9];
    else if (slot == 15) begin rd_exp = {17'd0, m_coll}; m_coll = '0; end
    else rd_exp = '0;
    rd_pend = 1; rd_tag = tag;
  endtask

  function automatic logic [31:0] ctl(int x, int y, int zx, int zy, int bank);
    return {2'(zy), 2'(bank), 12'(y), 2'(zx), 14'(x)};
  endfunction

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int s = 0; s < NS; s++) begin m_sh[s] = '0; m_act[s] = '0; end
    m_coll = '0; e1_v = 0; e2_v = 0; rd_pend = 0;
    repeat (3) @(negedge clk_i);
    vectors++; // R12 reset state
    if (pix_o !== '0 || pix_sel_o !== 1'b0 || reg_rdata_o !== '0) begin
      errors++;
      $display("FAIL R12 reset act=%h/%0d/%h exp=0/0/0", pix_o, pix_sel_o, reg_rdata_o);
    end
    rst_ni = 1;
    rd(15, "R12"); rd(9, "R12"); rd(14, "R12");

    // R1 image load
    for (int s = 0; s < NS; s++)
      for (int a = 0; a < 1024; a++) begin
        tick();
        mem_we_i = 1; mem_spr_i = 3'(s); mem_addr_i = 10'(a); mem_wdata_i = spr_px(s, a);
      end

    // park every sprite off the scanned area
    for (int s = 0; s < NS; s++) wr(9 + s, ctl(16000, 4000, 0, 0, 0));
    frame();
    rd(11, "R2");

    // R1 / R3 edges at unit zoom
    wr(11, ctl(40, 30, 0, 0, 2));
    rd(11, "R2");
    frame();
    for (int x = 36; x < 76; x++) pixel(x, 30, 1, 8'h5a, "R1");
    for (int y = 28; y < 64; y++) pixel(40, y, 1, 8'h33, "R1");
    pixel(71, 61, 1, 8'h11, "R3"); pixel(72, 61, 1, 8'h11, "R3");
    pixel(39, 30, 1, 8'h11, "R3"); pixel(71, 62, 1, 8'h11, "R3");

    // R5 priority where sprites 0 and 2 overlap
    wr(9, ctl(50, 35, 0, 0, 1));
    frame();
    for (int y = 36; y < 60; y += 3)
      for (int x = 45; x < 85; x++) pixel(x, y, 1, 8'hc4, "R5");
    rd(15, "R8");
    rd(15, "R9");

    // R3 magnified sprite
    wr(13, ctl(200, 100, 3, 1, 3));
    frame();
    for (int x = 195; x < 460; x += 3) pixel(x, 120, 1, 8'h01, "R3");
    pixel(455, 163, 1, 8'h02, "R3"); pixel(456, 163, 1, 8'h02, "R3");
    pixel(455, 164, 1, 8'h02, "R3"); pixel(200, 100, 1, 8'h02, "R3");

    // R7 geometry deferred, bank immediate
    wr(13, ctl(300, 100, 3, 1, 1));
    for (int x = 200; x < 260; x += 2) pixel(x, 110, 1, 8'h07, "R7");
    frame();
    for (int x = 200; x < 320; x += 2) pixel(x, 110, 1, 8'h07, "R7");

    // R10 unused slots
    wr(3, 32'hdeadbeef); wr(8, 32'h12345678); wr(15, 32'hffffffff);
    rd(3, "R10"); rd(8, "R10"); rd(0, "R10"); rd(13, "R10"); rd(15, "R10");

    // random scenes
    for (int r = 0; r < 10; r++) begin
      for (int s = 0; s < NS; s++)
        wr(9 + s, ctl($urandom_range(95), $urandom_range(63), $urandom_range(1),
                      $urandom_range(1), $urandom_range(3)));
      frame();
      for (int n = 0; n < 300; n++)
        pixel($urandom_range(223), $urandom_range(159), ($urandom_range(7) != 0),
              8'($urandom), "R5");
      rd(15, "R8");
    end
    rd(15, "R9");

    tick(); tick(); tick();
    finish_run();
  end
endmodule